// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns two request sources into one clean system reset. The first source is a supply-good level from an external comparator. The second is a push-button input that is active low. A low supply-good level asserts reset on the next clock edge. A button press asserts reset once a two-flop synchronizer and a debounce filter have accepted the press. While either source is active, a hold counter stays at zero. Reset is released only after both sources have been inactive for `TIMEOUT_CYC` consecutive clock edges. Because of this, even a one-cycle request produces a reset pulse of at least the full time-out.

The same internal state drives two outputs: an active-high reset and an active-low reset. A synchronous initialisation input, `init_n`, puts the block in the asserted-reset state. It also clears the hold counter and sets the button filter to "released". All pins are plain control levels. The block has no data stream and no handshake.

Top module: `rsup_top`

## Requirements
- R1: While `init_n` is low at a clock edge, and on the cycle after it, `sys_rst` is 1 and `sys_rst_n` is 0.
- R2: If `supply_ok` is 0 at a clock edge, `sys_rst` is 1 in the cycle that follows that edge.
- R3: A low `supply_ok`, or a pressed (accepted) button, clears the hold counter. `sys_rst` falls only after `TIMEOUT_CYC` consecutive edges at which `supply_ok` is 1 and the accepted button level is released.
- R4: A `supply_ok` dip of a single cycle still gives a reset that lasts the full `TIMEOUT_CYC` edges after the dip.
- R5: When the accepted button level is pressed (0), reset is asserted and stays asserted while the button stays pressed. It is released `TIMEOUT_CYC` edges after the accepted level returns to released (1).
- R6: The button input passes through two synchronizer flops. A new level is accepted only after the synchronized level has differed from the accepted level at `DEBOUNCE_CYC` consecutive edges. A pulse shorter than this does not change reset.
- R7: After initialisation the accepted button level is released (1), so a button input left high never causes a reset.
- R8: `sys_rst_n` is always the complement of `sys_rst`.
- R9: The hold counter saturates at `TIMEOUT_CYC` and does not wrap. Once reset is released, it stays released for as long as both sources stay inactive.
- R10: Driving `init_n` low in the middle of operation asserts reset again, restarts the full time-out and returns the filter to released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_n | input | 1 | Synchronous initialisation, active low |
| supply_ok | input | 1 | Supply-good level from the external comparator (1 = supply above threshold) |
| btn_n | input | 1 | Raw push-button level, active low, asynchronous |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
Two events can land on the same edge: the supply-good input returns high, and the debounce filter accepts a new button level (press or release). Both change whether the hold counter may count. The bench provokes this with a directed case: it releases the button and times a supply dip so that the supply returns at about the edge where the release is accepted. The random phase produces many more such overlaps. A cycle-accurate reference built from the requirements is compared with both outputs in every cycle, so a single cycle of early or late release is reported.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  // Accepted level of the active-low push button
  typedef enum logic {
    BTN_PRESSED  = 1'b0,
    BTN_RELEASED = 1'b1
  } btn_lvl_t;
endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic init_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!init_n) chain[0] <= 1'b1;
          else         chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!init_n) chain[i] <= 1'b1;
          else         chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce
  import rsup_pkg::*;
#(
  parameter int DEBOUNCE_CYC = 16
) (
  input  logic     clk,
  input  logic     init_n,
  input  logic     din,
  output btn_lvl_t level
);
  localparam int DW = (DEBOUNCE_CYC > 1) ? $clog2(DEBOUNCE_CYC) : 1;
  localparam logic [DW-1:0] LAST = DW'(DEBOUNCE_CYC - 1);

  logic [DW-1:0] run_q;
  btn_lvl_t      level_q;

  always_ff @(posedge clk) begin
    if (!init_n) begin
      level_q <= BTN_RELEASED;
      run_q   <= '0;
    end else if (din != logic'(level_q)) begin
      if (run_q == LAST) begin
        level_q <= btn_lvl_t'(din);
        run_q   <= '0;
      end else begin
        run_q <= run_q + DW'(1);
      end
    end else begin
      run_q <= '0;
    end
  end

  assign level = level_q;

  // R6: an input that agrees with the accepted level never flips it
  p_agree_keeps_r6: assert property (@(posedge clk) disable iff (!init_n)
    (din == logic'(level_q)) |=> $stable(level_q));

  // R6: a change of the accepted level needs a full run of differing samples
  p_flip_after_run_r6: assert property (@(posedge clk) disable iff (!init_n)
    (level_q != $past(level_q)) |-> ($past(run_q) == LAST));
endmodule

// File: rtl/rsup_hold_timer.sv
module rsup_hold_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic init_n,
  input  logic request,
  output logic rst_act
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_inc;
  logic          rst_q;

  assign cnt_inc = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!init_n || request) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (cnt_q != TERM) begin
      cnt_q <= cnt_inc;
      rst_q <= (cnt_inc != TERM);
    end
  end

  assign rst_act = rst_q;

  // R3: any active request leaves the counter cleared
  p_clear_r3: assert property (@(posedge clk) disable iff (!init_n)
    request |=> (cnt_q == '0 && rst_q));

  // R9: terminal count is held with reset released
  p_saturate_r9: assert property (@(posedge clk) disable iff (!init_n)
    (cnt_q == TERM && !request) |=> (cnt_q == TERM && !rst_q));

  // R4: a release only ever happens at terminal count
  p_release_full_r4: assert property (@(posedge clk) disable iff (!init_n)
    $fell(rst_q) |-> (cnt_q == TERM));
endmodule

// File: rtl/rsup_top.sv
module rsup_top
  import rsup_pkg::*;
#(
  parameter int TIMEOUT_CYC  = 1000,
  parameter int DEBOUNCE_CYC = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic init_n,
  input  logic supply_ok,
  input  logic btn_n,
  output logic sys_rst,
  output logic sys_rst_n
);
  logic     btn_synced;
  btn_lvl_t btn_level;
  logic     request;
  logic     rst_state;

  rsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .init_n (init_n),
    .din    (btn_n),
    .dout   (btn_synced)
  );

  rsup_debounce #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_deb (
    .clk    (clk),
    .init_n (init_n),
    .din    (btn_synced),
    .level  (btn_level)
  );

  assign request = !supply_ok || (btn_level == BTN_PRESSED);

  rsup_hold_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_hold (
    .clk     (clk),
    .init_n  (init_n),
    .request (request),
    .rst_act (rst_state)
  );

  assign sys_rst   = rst_state;
  assign sys_rst_n = ~rst_state;

  // R2: low supply at an edge means reset in the next cycle
  p_supply_low_r2: assert property (@(posedge clk) disable iff (!init_n)
    !supply_ok |=> sys_rst);

  // R5: an accepted press keeps reset on
  p_button_hold_r5: assert property (@(posedge clk) disable iff (!init_n)
    (btn_level == BTN_PRESSED) |=> sys_rst);
endmodule

// File: tb/sim_rsup_top.sv
module sim_rsup_top;
  localparam int TO = 40;
  localparam int DB = 6;

  logic clk = 1'b0;
  logic init_n = 1'b0;
  logic supply_ok = 1'b0;
  logic btn_n = 1'b1;
  logic sys_rst, sys_rst_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rsup_top #(.TIMEOUT_CYC(TO), .DEBOUNCE_CYC(DB), .SYNC_STAGES(2)) u0 (
    .clk(clk), .init_n(init_n), .supply_ok(supply_ok), .btn_n(btn_n),
    .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  // Reference state, built from the requirements
  logic m_s1, m_s2, m_lvl, m_rst;
  int   m_run, m_cnt;

  function automatic bit req_active(logic sup, logic lvl);
    return (!sup) || (lvl == 1'b0);
  endfunction

  function automatic int next_hold(int cnt, bit act);
    if (act) return 0;
    return (cnt < TO) ? cnt + 1 : TO;
  endfunction

  always @(posedge clk) begin
    if (!init_n) begin
      m_s1 = 1'b1; m_s2 = 1'b1; m_lvl = 1'b1; m_run = 0; m_cnt = 0; m_rst = 1'b1;
    end else begin
      m_cnt = next_hold(m_cnt, req_active(supply_ok, m_lvl));
      m_rst = (m_cnt < TO);
      if (m_s2 != m_lvl) begin
        if (m_run == DB - 1) begin m_lvl = m_s2; m_run = 0; end
        else m_run = m_run + 1;
      end else m_run = 0;
      m_s2 = m_s1;
      m_s1 = btn_n;
    end
  end

  task automatic chk(string req);
    checks++;
    if (sys_rst !== m_rst) begin
      errors++;
      $display("FAIL %s sys_rst actual %b expected %b at cycle %0d", req, sys_rst, m_rst, cycles);
    end
    checks++;
    if (sys_rst_n !== ~m_rst) begin
      errors++;
      $display("FAIL R8 sys_rst_n actual %b expected %b at cycle %0d", sys_rst_n, ~m_rst, cycles);
    end
  endtask

  task automatic step(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      chk(req);
    end
  endtask

  task automatic expect_level(logic v, string req);
    checks++;
    if (sys_rst !== v) begin
      errors++;
      $display("FAIL %s directed sys_rst actual %b expected %b", req, sys_rst, v);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240607));
    // R1: initialisation
    init_n = 1'b0; supply_ok = 1'b1; btn_n = 1'b1;
    step(3, "R1");
    expect_level(1'b1, "R1");
    init_n = 1'b1;
    // R7 / R3: button untouched, release after full time-out
    step(TO - 1, "R7");
    expect_level(1'b1, "R3");
    step(2, "R3");
    expect_level(1'b0, "R3");
    // R9: stays released well past terminal count
    step(3 * TO, "R9");
    expect_level(1'b0, "R9");
    // R4: single-cycle supply dip
    supply_ok = 1'b0; step(1, "R2");
    expect_level(1'b1, "R2");
    supply_ok = 1'b1; step(TO + 4, "R4");
    expect_level(1'b0, "R4");
    // R6: glitch one cycle shorter than the filter
    btn_n = 1'b0; step(DB - 1, "R6");
    btn_n = 1'b1; step(DB + 6, "R6");
    expect_level(1'b0, "R6");
    // R5: long press, then release
    btn_n = 1'b0; step(DB + 10, "R5");
    expect_level(1'b1, "R5");
    step(50, "R5");
    btn_n = 1'b1; step(DB + TO + 4, "R5");
    expect_level(1'b0, "R5");
    // R3: press, release, supply returns near the release-accept edge
    btn_n = 1'b0; step(DB + 4, "R5");
    btn_n = 1'b1; step(1, "R3");
    supply_ok = 1'b0; step(DB + 1, "R3");
    supply_ok = 1'b1; step(TO + 8, "R3");
    // R10: re-initialise mid-run
    step(5, "R9");
    init_n = 1'b0; step(2, "R10");
    expect_level(1'b1, "R10");
    init_n = 1'b1; step(TO + 3, "R10");
    // Random phase: bouncy button and dipping supply
    for (int k = 0; k < 6000; k++) begin
      if (($urandom % 100) < 3) supply_ok = ~supply_ok;
      else if (!supply_ok && ($urandom % 4) == 0) supply_ok = 1'b1;
      if (($urandom % 100) < 8) btn_n = ~btn_n;
      step(1, "R3");
    end
    supply_ok = 1'b1; btn_n = 1'b1;
    step(TO + DB + 6, "R9");
    expect_level(1'b0, "R9");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule